// File: doc/BRIEF.md
# Programmable Pickup/Dropout Delay Timer Gate

This block turns one logic input into a delayed logic output, as a timer element inside protective-relay programmable logic. The output rises only after the input has stayed high for a programmed pickup delay. Once the output is high and the input falls, the output is held for a programmed dropout delay and then clears. If the input falls while the output is still low, the dropout delay plays no part.

Both delays are counted on one of two external time bases. One is a single-clock pulse that marks each power-system cycle. The other is a single-clock pulse that marks each second. A unit-select input picks which pulse advances the count. The block carries a two-bit setting-group field. It runs only while the active setting group matches that field. When the groups differ, the block is held idle with its output low.

A protection design uses six such gates side by side, each with its own settings. Input selection and tick generation belong to the surrounding logic.

Top module: `delay_gate`

## Requirements
- R1: While rst_n is low at a rising clock edge, the gate returns to idle with gate_out low and the delay count cleared.
- R2: With the input held high, gate_out rises on the clock edge after the on_dly-th selected tick is seen. Ticks are counted from the cycle after the edge at which the input was first seen high.
- R3: If the input falls before the pickup delay completes, gate_out stays low and the pickup count restarts from zero at the next rising input.
- R4: When the input falls while gate_out is high, gate_out stays high until the off_dly-th selected tick after the fall, then clears at that clock edge.
- R5: An input that falls while gate_out is low leaves gate_out low, whatever off_dly holds.
- R6: If the input rises again during the dropout interval, gate_out stays high and the dropout count is cleared, so a later fall starts a full off_dly interval.
- R7: An on_dly of zero makes gate_out rise at the first edge that sees the input high. An off_dly of zero makes it clear at the first edge that sees the input low. Neither case needs a tick.
- R8: Unit select: use_sec=0 counts only cyc_tick, and use_sec=1 counts only sec_tick. The tick that is not selected has no effect.
- R9: Setting groups 1 to 4 are coded 0 to 3 on grp_cfg and grp_act. At any edge where the two codes differ, the gate goes idle, its count clears and gate_out is low from that edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gate_in | input | 1 | Logic input to be delayed |
| cyc_tick | input | 1 | One-clock pulse per power-system cycle |
| sec_tick | input | 1 | One-clock pulse per second |
| use_sec | input | 1 | 0: count cycle ticks, 1: count second ticks |
| on_dly | input | DLY_W | Pickup delay in ticks |
| off_dly | input | DLY_W | Dropout delay in ticks |
| grp_cfg | input | 2 | Configured setting group code (0..3 = group 1..4) |
| grp_act | input | 2 | Active setting group code (0..3 = group 1..4) |
| gate_out | output | 1 | Delayed logic output |

## Verification
The bench targets inputs that drop one tick short of pickup; a design that failed to restart the count would then fire early on the next pulse. It reasserts the input midway through dropout; a design that kept the old dropout count would clear the output too soon after the following fall. It uses zero delays with no ticks present; a design that waited for a tick would stall. It toggles the unselected tick; a design that ignored use_sec would count it. It switches the active group mid-count; a design that only froze its counter, instead of clearing it, would resume with a stale count.

// File: rtl/dg_pkg.sv
// Package: shared state encoding and widths for the delay gate.
// Assumes: nothing beyond IEEE 1800-2017.
package dg_pkg;
    localparam int GROUP_W = 2;

    typedef enum logic [1:0] {
        DG_IDLE    = 2'd0,
        DG_PICKUP  = 2'd1,
        DG_HELD    = 2'd2,
        DG_DROPOUT = 2'd3
    } dg_state_e;
endpackage

// File: rtl/dg_tick_sel.sv
// Module: picks the tick stream that advances the delay count.
// Assumes: both tick inputs are single-clock pulses synchronous to clk.
module dg_tick_sel (
    input  logic cyc_tick,
    input  logic sec_tick,
    input  logic use_sec,
    output logic tick
);
    // Select the time base named by the unit setting.
    always_comb begin
        tick = use_sec ? sec_tick : cyc_tick;
    end
endmodule

// File: rtl/dg_group_match.sv
// Module: enables the gate only while the active group equals its own.
// Assumes: group codes are static between clock edges.
module dg_group_match
    import dg_pkg::*;
(
    input  logic [GROUP_W-1:0] grp_cfg,
    input  logic [GROUP_W-1:0] grp_act,
    output logic               enable
);
    // Compare the configured and active group codes.
    always_comb begin
        enable = (grp_cfg == grp_act);
    end
endmodule

// File: rtl/dg_delay_cnt.sv
// Module: shared tick counter for the pickup and dropout intervals.
// Assumes: the controller deasserts busy for at least one edge between intervals,
// so every interval starts from a zero count.
module dg_delay_cnt #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             busy,
    input  logic             advance,
    input  logic [DLY_W-1:0] target,
    output logic             expired
);
    localparam int EXT_W = DLY_W + 1;

    logic [DLY_W-1:0] cnt_q;
    logic [EXT_W-1:0] cnt_next_ext;

    // Expire when the count reaches the target, either already or with this tick.
    always_comb begin
        cnt_next_ext = {1'b0, cnt_q} + EXT_W'(1);
        expired = busy && (({1'b0, cnt_q} >= {1'b0, target}) ||
                           (advance && (cnt_next_ext >= {1'b0, target})));
    end

    // Count selected ticks while an interval runs; clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || !busy || expired) begin
            cnt_q <= '0;
        end else if (advance) begin
            cnt_q <= cnt_next_ext[DLY_W-1:0];
        end
    end

    // R8: without a tick, and short of expiry, the count holds its value.
    assert_count_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !advance && !clear && !expired) |=> (cnt_q == $past(cnt_q)));

    // R9: a group mismatch leaves the count at zero on the following cycle.
    assert_count_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt_q == '0));
endmodule

// File: rtl/dg_ctrl.sv
// Module: pickup/dropout state machine that owns the gate output.
// Assumes: expired comes from dg_delay_cnt and refers to the interval of the current state.
module dg_ctrl
    import dg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic gate_in,
    input  logic on_zero,
    input  logic off_zero,
    input  logic expired,
    output logic busy,
    output logic sel_off,
    output logic gate_out
);
    dg_state_e state_q, state_d;

    // Next-state choice from input level, interval expiry and zero settings.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DG_IDLE:    if (gate_in) state_d = on_zero ? DG_HELD : DG_PICKUP;
            DG_PICKUP:  if (!gate_in) state_d = DG_IDLE;
                        else if (expired) state_d = DG_HELD;
            DG_HELD:    if (!gate_in) state_d = off_zero ? DG_IDLE : DG_DROPOUT;
            DG_DROPOUT: if (gate_in) state_d = DG_HELD;
                        else if (expired) state_d = DG_IDLE;
            default:    state_d = DG_IDLE;
        endcase
        if (!enable) state_d = DG_IDLE;
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DG_IDLE;
        else        state_q <= state_d;
    end

    // Decode counter control and the output from the state.
    always_comb begin
        busy     = (state_q == DG_PICKUP) || (state_q == DG_DROPOUT);
        sel_off  = (state_q == DG_DROPOUT);
        gate_out = (state_q == DG_HELD) || (state_q == DG_DROPOUT);
    end

    // R2: with the input held high and the gate enabled, a high output stays high.
    assert_held_stays_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && gate_in && gate_out) |=> gate_out);

    // R5: a low input with a low output keeps the output low.
    assert_low_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_in && !gate_out) |=> !gate_out);
endmodule

// File: rtl/delay_gate.sv
// Module: top of the programmable pickup/dropout delay timer gate.
// Assumes: ticks and settings are synchronous to clk; group codes 0..3 mean groups 1..4.
module delay_gate #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_in,
    input  logic             cyc_tick,
    input  logic             sec_tick,
    input  logic             use_sec,
    input  logic [DLY_W-1:0] on_dly,
    input  logic [DLY_W-1:0] off_dly,
    input  logic [1:0]       grp_cfg,
    input  logic [1:0]       grp_act,
    output logic             gate_out
);
    logic tick, enable, expired, busy, sel_off;
    logic on_zero, off_zero;
    logic [DLY_W-1:0] target;

    dg_tick_sel u_tick (
        .cyc_tick (cyc_tick),
        .sec_tick (sec_tick),
        .use_sec  (use_sec),
        .tick     (tick)
    );

    dg_group_match u_grp (
        .grp_cfg (grp_cfg),
        .grp_act (grp_act),
        .enable  (enable)
    );

    // Choose the interval length for the running phase and flag zero settings.
    always_comb begin
        target   = sel_off ? off_dly : on_dly;
        on_zero  = (on_dly == '0);
        off_zero = (off_dly == '0);
    end

    dg_delay_cnt #(.DLY_W(DLY_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (!enable),
        .busy    (busy),
        .advance (tick),
        .target  (target),
        .expired (expired)
    );

    dg_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .gate_in  (gate_in),
        .on_zero  (on_zero),
        .off_zero (off_zero),
        .expired  (expired),
        .busy     (busy),
        .sel_off  (sel_off),
        .gate_out (gate_out)
    );

    // R9: a group mismatch drives the output low at the next edge.
    assert_group_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (grp_cfg != grp_act) |=> !gate_out);

    // R2: the output only rises after an edge that saw the input high.
    assert_rise_needs_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_out) |-> $past(gate_in));

    // R7: a zero dropout setting clears the output at the first low-input edge.
    assert_zero_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_out && !gate_in && (off_dly == '0)) |=> !gate_out);
endmodule

// File: tb/tb_delay_gate.sv
module tb_delay_gate;
    localparam int DLY_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gate_in = 1'b0, cyc_tick = 1'b0, sec_tick = 1'b0, use_sec = 1'b0;
    logic [DLY_W-1:0] on_dly = '0, off_dly = '0;
    logic [1:0] grp_cfg = 2'd0, grp_act = 2'd0;
    logic gate_out;

    int checks = 0;
    int errors = 0;

    // Reference model state: 0 idle, 1 pickup, 2 held, 3 dropout.
    int m_st = 0;
    int m_cnt = 0;

    always #2 clk = ~clk;

    delay_gate #(.DLY_W(DLY_W)) dut (
        .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .cyc_tick(cyc_tick),
        .sec_tick(sec_tick), .use_sec(use_sec), .on_dly(on_dly), .off_dly(off_dly),
        .grp_cfg(grp_cfg), .grp_act(grp_act), .gate_out(gate_out)
    );

    function automatic bit model_out();
        return (m_st == 2) || (m_st == 3);
    endfunction

    function automatic bit model_expired(int cnt, int tgt, bit tk);
        return (cnt >= tgt) || (tk && (cnt + 1 >= tgt));
    endfunction

    // Advance the reference model by one clock edge from the requirements.
    function automatic void model_step();
        bit tk = use_sec ? sec_tick : cyc_tick;
        int ns = m_st;
        int nc = m_cnt;
        if (!rst_n || grp_cfg != grp_act) begin
            ns = 0; nc = 0;
        end else begin
            case (m_st)
                0: begin nc = 0; if (gate_in) ns = (on_dly == 0) ? 2 : 1; end
                1: if (!gate_in) begin ns = 0; nc = 0; end
                   else if (model_expired(m_cnt, int'(on_dly), tk)) begin ns = 2; nc = 0; end
                   else if (tk) nc = m_cnt + 1;
                2: begin nc = 0; if (!gate_in) ns = (off_dly == 0) ? 0 : 3; end
                default: if (gate_in) begin ns = 2; nc = 0; end
                   else if (model_expired(m_cnt, int'(off_dly), tk)) begin ns = 0; nc = 0; end
                   else if (tk) nc = m_cnt + 1;
            endcase
        end
        m_st = ns; m_cnt = nc;
    endfunction

    task automatic check(string tag, bit exp);
        checks++;
        if (gate_out !== exp) begin
            errors++;
            $display("FAIL %s: gate_out actual=%0b expected=%0b at %0t", tag, gate_out, exp, $time);
        end
    endtask

    // One clock with the given stimulus; compare against the model after the edge.
    task automatic step(bit din, bit ct, bit st, string tag);
        gate_in = din; cyc_tick = ct; sec_tick = st;
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(tag, model_out());
    endtask

    task automatic expect_now(string tag, bit exp);
        checks++;
        if (gate_out !== exp) begin
            errors++;
            $display("FAIL %s: gate_out actual=%0b expected=%0b at %0t", tag, gate_out, exp, $time);
        end
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog (R1..R9 run incomplete): actual=hung expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int seed = 32'h5eed_1234;
        void'($urandom(seed));
        @(negedge clk);
        repeat (3) step(1'b1, 1'b1, 1'b1, "R1 reset");
        expect_now("R1 reset low", 1'b0);
        rst_n = 1'b1;

        // R2: pickup of 3 cycle ticks, one tick per clock.
        on_dly = 3; off_dly = 2; use_sec = 0;
        step(1, 0, 0, "R2 enter");
        step(1, 1, 0, "R2 t1");
        step(1, 1, 0, "R2 t2");
        expect_now("R2 still low before last tick", 1'b0);
        step(1, 1, 0, "R2 t3");
        expect_now("R2 high after third tick", 1'b1);

        // R4: dropout of 2 ticks.
        step(0, 0, 0, "R4 fall");
        step(0, 1, 0, "R4 t1");
        expect_now("R4 held during dropout", 1'b1);
        step(0, 1, 0, "R4 t2");
        expect_now("R4 cleared after dropout", 1'b0);

        // R3 and R5: drop one tick short, then restart from zero.
        step(1, 0, 0, "R3 enter");
        step(1, 1, 0, "R3 t1");
        step(1, 1, 0, "R3 t2");
        step(0, 1, 0, "R3 drop");
        expect_now("R5 low after early drop", 1'b0);
        step(1, 0, 0, "R3 reenter");
        step(1, 1, 0, "R3 t1b");
        step(1, 1, 0, "R3 t2b");
        expect_now("R3 count restarted", 1'b0);
        step(1, 1, 0, "R3 t3b");
        expect_now("R3 pickup after full delay", 1'b1);

        // R6: reassert mid-dropout, then a full new dropout.
        off_dly = 3;
        step(0, 0, 0, "R6 fall");
        step(0, 1, 0, "R6 t1");
        step(0, 1, 0, "R6 t2");
        step(1, 0, 0, "R6 reassert");
        expect_now("R6 high after reassert", 1'b1);
        step(0, 0, 0, "R6 fall2");
        step(0, 1, 0, "R6 t1b");
        step(0, 1, 0, "R6 t2b");
        expect_now("R6 dropout restarted", 1'b1);
        step(0, 1, 0, "R6 t3b");
        expect_now("R6 cleared", 1'b0);

        // R7: zero delays need no ticks.
        on_dly = 0; off_dly = 0;
        step(1, 0, 0, "R7 zero on");
        expect_now("R7 rise without tick", 1'b1);
        step(0, 0, 0, "R7 zero off");
        expect_now("R7 fall without tick", 1'b0);

        // R8: second base selected, cycle ticks ignored.
        on_dly = 2; off_dly = 1; use_sec = 1;
        step(1, 0, 0, "R8 enter");
        repeat (5) step(1, 1, 0, "R8 cyc ignored");
        expect_now("R8 low with only cycle ticks", 1'b0);
        step(1, 0, 1, "R8 s1");
        step(1, 0, 1, "R8 s2");
        expect_now("R8 high after two second ticks", 1'b1);

        // R9: group mismatch forces low and clears the count.
        grp_act = 2'd2;
        step(1, 0, 1, "R9 mismatch");
        expect_now("R9 low on mismatch", 1'b0);
        step(1, 0, 1, "R9 mismatch hold");
        grp_act = 2'd0;
        step(1, 0, 0, "R9 enter again");
        step(1, 0, 1, "R9 s1");
        expect_now("R9 count restarted after mismatch", 1'b0);
        step(1, 0, 1, "R9 s2");
        expect_now("R9 pickup after regroup", 1'b1);

        // Random phase: R2 R3 R4 R6 R8 R9 against the model.
        for (int blk = 0; blk < 60; blk++) begin
            on_dly  = DLY_W'($urandom_range(0, 5));
            off_dly = DLY_W'($urandom_range(0, 5));
            use_sec = 1'($urandom_range(0, 1));
            grp_cfg = 2'($urandom_range(0, 3));
            for (int i = 0; i < 60; i++) begin
                bit din = ($urandom_range(0, 9) < 7) ? gate_in : ~gate_in;
                grp_act = ($urandom_range(0, 19) == 0) ? 2'($urandom_range(0, 3)) : grp_cfg;
                step(din, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R2/R4/R9 random");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule